// File: doc/BRIEF.md
# Serial Register Port with Instruction Phase

This block is a slave port that lets an external controller read and write a small bank of control registers over a few serial pins. These are a select line (active low), a serial clock, an active-high port reset, a data-in/data-out pair with its own output enable that stands for a shared bidirectional pin, and a separate data-out pin with its own enable. All serial inputs are brought into the system clock domain by synchronizers. Serial clock edges are found by edge detection, so the serial clock must run well below the system clock. Each serial half period must span at least six system clock cycles.

A transfer is an instruction byte followed by a data phase. The instruction byte carries a read/write flag and a 6-bit register address. The data phase moves the whole addressed register, so its length depends on the address. Several transfers may follow one another within one select window. Register 0 is the port's own control register. It sets the bit order and whether read data leaves on the shared pin (2-wire) or on the dedicated pin (3-wire).

Top module: `ser_regport`

## Requirements
- R1: An instruction byte is eight serial bits sampled on rising serial clock edges. Instruction bit 7 = 1 selects a read and 0 a write, bit 6 is ignored, and bits 5:0 give the address.
- R2: The data phase of address a (a < NUM_REGS) is ((a mod MAX_BYTES)+1)*8 bits. With the defaults that gives 1,2,3,4,1,2,3,4 bytes for addresses 0..7. After the data phase the next eight rising edges form a new instruction byte, within the same select window.
- R3: Write data is sampled on rising edges and committed only after the last data bit. A later read returns exactly the written value.
- R4: Read data changes on falling serial clock edges. Data bit k of the phase is valid from the k-th falling edge after the instruction's last rising edge until the next falling edge.
- R5: Control register bit 0 = 0 selects MSB-first and 1 selects LSB-first, for both phases. In either order the full register value is moved as one number.
- R6: Control bit 1 = 0 selects 2-wire: read data appears on dio_out with dio_oe high and dout_oe low. Control bit 1 = 1 selects 3-wire: read data appears on dout with dout_oe high and dio_oe never high.
- R7: While sel_n is high, both output enables are low. Raising sel_n aborts the current transfer and leaves the register being written unchanged.
- R8: A port_rst pulse aborts the transfer in progress. The next eight rising edges form a new instruction byte, and all register contents are kept, including a register whose write was cut short.
- R9: An address >= NUM_REGS reads as zero, ignores write data, and has a one-byte data phase.
- R10: A new control register value takes effect from the instruction phase that follows the write, not during the write's own data phase.
- R11: After rst the control register is 0 (MSB-first, 2-wire) and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Port select, active low |
| sck | input | 1 | Serial clock |
| port_rst | input | 1 | Active-high port reset, keeps registers |
| dio_in | input | 1 | Shared data pin, input side |
| dio_out | output | 1 | Shared data pin, output side |
| dio_oe | output | 1 | Shared data pin output enable |
| dout | output | 1 | Dedicated data-out pin (3-wire) |
| dout_oe | output | 1 | Dedicated data-out pin output enable |

## Verification
A wrong bit counter or a wrong length lookup shows up in the same transfer. The output enable then stays up or drops at the wrong bit, and every later transfer in that select window is misframed, so the read values come back garbled. A premature or missed commit, or a bad reaction to an abort, only shows on the next read of that register. For that reason every abort scenario is followed at once by a read of the register that was being written. A wrong bit-order or wire-mode state shows on the first read after the control register changes: the data is bit-reversed, or it is missing from the expected pin.

// File: rtl/ser_regport_pkg.sv
package ser_regport_pkg;

  localparam int ADDR_W  = 6;
  localparam int INSTR_W = 8;
  localparam int CTRL_W  = 8;

  typedef enum logic {PH_INSTR, PH_DATA} phase_t;

  // Bytes moved in the data phase of address a.
  function automatic int unsigned reg_bytes(logic [ADDR_W-1:0] a,
                                            int unsigned nregs,
                                            int unsigned maxb);
    if (int'(a) < int'(nregs)) return (int'(a) % maxb) + 1;
    return 1;
  endfunction

endpackage

// File: rtl/ser_regport_sync.sv
module ser_regport_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= RST_VAL;
      else if (g == 0) chain[g] <= d;
      else chain[g] <= chain[(g == 0) ? 0 : g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ser_regport_regfile.sv
module ser_regport_regfile
  import ser_regport_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rd_word,
  output logic              lsb_first,
  output logic              three_wire
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  typedef enum logic [1:0] {SRC_CTRL, SRC_MEM, SRC_ZERO} src_t;

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic [DATA_W-1:0] mem_q;
  logic [CTRL_W-1:0] ctrl_q;
  src_t              src_q;

  // Entry 0 of the array is unused: address 0 lives in ctrl_q.
  always_ff @(posedge clk) begin
    if (we && waddr != '0) mem[waddr[IDX_W-1:0]] <= wdata;
    mem_q <= mem[raddr[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      src_q  <= SRC_CTRL;
    end else begin
      if (we && waddr == '0) ctrl_q <= wdata[CTRL_W-1:0];
      if (raddr == '0) src_q <= SRC_CTRL;
      else if (int'(raddr) < NUM_REGS) src_q <= SRC_MEM;
      else src_q <= SRC_ZERO;
    end
  end

  always_comb begin
    case (src_q)
      SRC_CTRL: rd_word = DATA_W'(ctrl_q);
      SRC_MEM:  rd_word = mem_q;
      default:  rd_word = '0;
    endcase
  end

  assign lsb_first  = ctrl_q[0];
  assign three_wire = ctrl_q[1];

  // R9: the sequencer never commits to an unmapped address
  a_r9_no_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < NUM_REGS));

  // R10: control bits only move on a commit
  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ctrl_q));
endmodule

// File: rtl/ser_regport_seq.sv
module ser_regport_seq
  import ser_regport_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int MAX_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_hi,
  input  logic                      abort,
  input  logic                      rise,
  input  logic                      fall,
  input  logic                      din,
  input  logic                      lsb_first,
  input  logic                      three_wire,
  input  logic [MAX_BYTES*8-1:0]    rd_word,
  output logic [ADDR_W-1:0]         addr,
  output logic                      we,
  output logic [MAX_BYTES*8-1:0]    wdata,
  output logic                      out_bit,
  output logic                      dio_oe,
  output logic                      dout_oe
);
  localparam int DATA_W = MAX_BYTES * 8;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  phase_t            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q, sh_n, rd_shift;
  logic              rd_q, out_q, dio_oe_q, dout_oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  nbits, rd_idx;
  logic [INSTR_W-1:0] instr;
  logic              last_bit, active;

  assign active = !cs_hi && !abort;
  assign sh_n   = lsb_first ? {din, sh_q[DATA_W-1:1]} : {sh_q[DATA_W-2:0], din};
  assign instr  = lsb_first ? sh_n[DATA_W-1 -: INSTR_W] : sh_n[INSTR_W-1:0];
  assign nbits  = CNT_W'(reg_bytes(addr_q, NUM_REGS, MAX_BYTES) * 8);
  assign last_bit = (phase_q == PH_DATA) && (cnt_q == nbits - 1'b1);
  assign wdata  = lsb_first ? (sh_n >> (CNT_W'(DATA_W) - nbits)) : sh_n;
  assign we     = active && rise && last_bit && !rd_q && (int'(addr_q) < NUM_REGS);
  assign rd_idx = lsb_first ? cnt_q : (nbits - 1'b1 - cnt_q);
  assign rd_shift = rd_word >> rd_idx;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      phase_q <= PH_INSTR;
      cnt_q   <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      if (rst) addr_q <= '0;
    end else if (rise) begin
      if (phase_q == PH_INSTR) begin
        if (cnt_q == CNT_W'(INSTR_W - 1)) begin
          phase_q <= PH_DATA;
          rd_q    <= instr[7];
          addr_q  <= instr[ADDR_W-1:0];
          cnt_q   <= '0;
          sh_q    <= '0;
        end else begin
          sh_q  <= sh_n;
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (last_bit) begin
        phase_q <= PH_INSTR;
        cnt_q   <= '0;
        sh_q    <= '0;
      end else begin
        sh_q  <= sh_n;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= 1'b0;
      dio_oe_q  <= 1'b0;
      dout_oe_q <= 1'b0;
    end else begin
      if (active && fall && phase_q == PH_DATA && rd_q) out_q <= rd_shift[0];
      dio_oe_q  <= active && phase_q == PH_DATA && rd_q && !three_wire;
      dout_oe_q <= active && phase_q == PH_DATA && rd_q && three_wire;
    end
  end

  assign addr    = addr_q;
  assign out_bit = out_q;
  assign dio_oe  = dio_oe_q;
  assign dout_oe = dout_oe_q;

  // R7: select high releases both pins on the next cycle
  a_r7_release_on_deselect: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (!dio_oe_q && !dout_oe_q));

  // R8: port reset returns to the start of an instruction byte
  a_r8_abort_to_instr: assert property (@(posedge clk) disable iff (rst)
    abort |=> (phase_q == PH_INSTR && cnt_q == '0));

  // R2: the data-phase counter stays within the register length
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DATA) |-> (cnt_q < nbits));

  // R4: read data moves only on a falling serial edge
  a_r4_out_on_fall: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(out_q));
endmodule

// File: rtl/ser_regport.sv
module ser_regport
  import ser_regport_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int MAX_BYTES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic sck,
  input  logic port_rst,
  input  logic dio_in,
  output logic dio_out,
  output logic dio_oe,
  output logic dout,
  output logic dout_oe
);
  localparam int DATA_W = MAX_BYTES * 8;

  logic [3:0] pins_s;
  logic       sck_q, rise, fall;
  logic       we, lsb_first, three_wire, out_bit;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rd_word;

  ser_regport_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst(rst),
    .d({sel_n, sck, port_rst, dio_in}),
    .q(pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else sck_q <= pins_s[2];
  end

  assign rise = pins_s[2] && !sck_q;
  assign fall = !pins_s[2] && sck_q;

  ser_regport_seq #(.NUM_REGS(NUM_REGS), .MAX_BYTES(MAX_BYTES)) u_seq (
    .clk(clk), .rst(rst),
    .cs_hi(pins_s[3]), .abort(pins_s[1]),
    .rise(rise), .fall(fall), .din(pins_s[0]),
    .lsb_first(lsb_first), .three_wire(three_wire),
    .rd_word(rd_word),
    .addr(addr), .we(we), .wdata(wdata),
    .out_bit(out_bit), .dio_oe(dio_oe), .dout_oe(dout_oe)
  );

  ser_regport_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .we(we), .waddr(addr), .wdata(wdata), .raddr(addr),
    .rd_word(rd_word), .lsb_first(lsb_first), .three_wire(three_wire)
  );

  assign dio_out = out_bit;
  assign dout    = out_bit;

  // R6: the two output pins are never enabled together
  a_r6_one_pin: assert property (@(posedge clk) disable iff (rst)
    !(dio_oe && dout_oe));
endmodule

// File: tb/tb_ser_regport.sv
module tb_ser_regport;
  localparam int HALF = 8;

  logic clk = 0, rst = 1;
  logic sel_n = 1, sck = 0, port_rst = 0, dio_in = 0;
  logic dio_out, dio_oe, dout, dout_oe;

  int checks = 0, errors = 0;
  logic [31:0] mdl [8];
  logic [1:0]  cfg = 2'b00;

  always #10 clk = ~clk;

  ser_regport dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sck(sck), .port_rst(port_rst),
    .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe),
    .dout(dout), .dout_oe(dout_oe)
  );

  function automatic int len_of(logic [5:0] a);
    return (a < 8) ? (int'(a) % 4) + 1 : 1;
  endfunction

  function automatic logic [31:0] mask_of(logic [5:0] a);
    return (len_of(a) == 4) ? 32'hFFFF_FFFF : ((32'h1 << (len_of(a) * 8)) - 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) dio_in = b;
    repeat (HALF) @(negedge clk);
    sck = 1;
    repeat (HALF) @(negedge clk);
    sck = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic select;
    @(negedge clk) sel_n = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic deselect;
    @(negedge clk) sel_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_instr(input bit rd, input logic [5:0] a);
    logic [7:0] ins;
    ins = {rd, 1'($urandom), a};
    for (int i = 0; i < 8; i++) send_bit(cfg[0] ? ins[i] : ins[7-i]);
  endtask

  task automatic xfer(input bit rd, input logic [5:0] a, input logic [31:0] wv,
                      output logic [31:0] rv, output bit oe_ok);
    int n;
    n = len_of(a) * 8;
    rv = '0;
    oe_ok = 1;
    send_instr(rd, a);
    for (int i = 0; i < n; i++) begin
      int pos;
      pos = cfg[0] ? i : n - 1 - i;
      if (rd) begin
        rv[pos] = cfg[1] ? dout : dio_out;
        if (dio_oe !== !cfg[1] || dout_oe !== cfg[1]) oe_ok = 0;
        send_bit(1'($urandom));
      end else begin
        send_bit(wv[pos]);
      end
    end
    if (!rd && a < 8) begin
      mdl[a] = wv & mask_of(a);
      if (a == 0) cfg = mdl[0][1:0];
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    logic [31:0] d; bit ok;
    select; xfer(0, a, v, d, ok); deselect;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a);
    logic [31:0] v; bit ok;
    select; xfer(1, a, '0, v, ok); deselect;
    check(req, v, (a < 8) ? mdl[a] : 32'h0);
    check({req, " oe"}, 32'(ok), 32'd1);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<190000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v; bit ok;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (5) @(negedge clk);

    // R11: reset state
    check("R11 dio_oe", 32'(dio_oe), 0);
    check("R11 dout_oe", 32'(dout_oe), 0);
    rd_chk("R11 ctrl reset", 6'd0);

    // R1 R2 R3 R4: each mapped width, written then read
    for (int a = 1; a < 8; a++) wr(6'(a), 32'hA5C3_9E17 ^ (32'(a) * 32'h0101_0101));
    for (int a = 1; a < 8; a++) rd_chk("R3 readback", 6'(a));

    // R2: back-to-back transfers in one select window
    select;
    xfer(0, 6'd2, 32'h00_5A_3C, v, ok);
    xfer(1, 6'd2, '0, v, ok);
    check("R2 same window", v, mdl[2]);
    xfer(1, 6'd3, '0, v, ok);
    check("R2 next framing", v, mdl[3]);
    deselect;

    // R9: unmapped address, one byte, reads zero, then framing continues
    select;
    xfer(0, 6'd40, 32'hFF, v, ok);
    xfer(1, 6'd40, '0, v, ok);
    check("R9 unmapped read", v, 32'h0);
    xfer(1, 6'd5, '0, v, ok);
    check("R9 framing after unmapped", v, mdl[5]);
    deselect;

    // R5 R10: switch to LSB-first; following transfers use it
    wr(6'd0, 32'h01);
    rd_chk("R10 ctrl after write", 6'd0);
    wr(6'd7, 32'h1234_5678);
    rd_chk("R5 lsb-first", 6'd7);

    // R6: 3-wire mode, read on dedicated pin
    wr(6'd0, 32'h02);
    rd_chk("R6 three-wire", 6'd3);
    wr(6'd0, 32'h00);
    rd_chk("R6 two-wire", 6'd6);

    // R8: port reset mid-write keeps register, next byte is instruction
    select;
    send_instr(0, 6'd3);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    @(negedge clk) port_rst = 1;
    repeat (4) @(negedge clk);
    port_rst = 0;
    repeat (6) @(negedge clk);
    xfer(1, 6'd3, '0, v, ok);
    check("R8 write aborted", v, mdl[3]);
    deselect;

    // R7: deselect mid-read releases pins and mid-write keeps register
    select;
    send_instr(1, 6'd4);
    send_bit(0);
    @(negedge clk) sel_n = 1;
    repeat (6) @(negedge clk);
    check("R7 dio_oe high-z", 32'(dio_oe), 0);
    check("R7 dout_oe high-z", 32'(dout_oe), 0);
    select;
    send_instr(0, 6'd7);
    for (int i = 0; i < 20; i++) send_bit(1'b0);
    deselect;
    rd_chk("R7 write aborted", 6'd7);

    // R1 R3 R5 R6 R9 R10: random mix
    for (int k = 0; k < 40; k++) begin
      logic [5:0] a;
      a = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 8);
      if ($urandom % 2) begin
        if (a == 0) wr(a, 32'($urandom % 4));
        else wr(a, $urandom);
      end else begin
        rd_chk("R1 random read", a);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule